// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block is the bit-timing engine of an I2C master. It owns the SCL line and the START/STOP edges on SDA, and it tells the byte-level logic above it when SDA may change and when SDA should be read. Every cycle count comes from three 32-bit timing words. Each word packs two 16-bit counts.

The controller above issues one command at a time over a valid/ready handshake: start, bit, stop or no-op. A start pulls SDA low while SCL is high and holds that state for a lead-in time. SCL then falls, and the engine parks with SCL low to wait for the next command. A bit command runs one low phase and one high phase. The low phase carries a drive strobe, and the data bit appears on SDA one cycle after that strobe. The high phase carries a sample strobe. A stop runs a low phase and a high phase with SDA held low, then releases SDA. The engine then stays not-ready for a bus-free time.

Both phase lengths include fixed overheads on top of the programmed counts: 2 cycles on the low phase and 7 on the high phase. The timing words are captured when a start is accepted, so software can rewrite them during a transfer without disturbing it.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, scl_o and sda_o are 1, cmd_ready_o is 1 and both strobes are 0.
- R2: When a start (cmd_i = 1) is accepted from idle, sda_o is 0 with scl_o still 1 from the next cycle on. scl_o falls exactly LEAD cycles after the accepting edge, where LEAD is bits 15:0 of timing word 2 (LEAD >= 1).
- R3: When a bit (cmd_i = 2) is accepted, scl_o stays 0 for LOW+2 cycles counted from the accepting edge and then rises. LOW is bits 31:16 of timing word 1 (1..1023).
- R4: In a bit, scl_o stays 1 for HIGH+7 cycles and then falls. HIGH is bits 31:16 of timing word 0 (1..1023).
- R5: drive_stb_o pulses for one cycle, XMIT cycles after the accepting edge of a bit. XMIT is bits 15:0 of word 1 (XMIT <= LOW+1). One cycle after the pulse, sda_o takes the value bit_i had at acceptance.
- R6: sample_stb_o pulses for one cycle, RCV cycles after scl_o rises in a bit. RCV is bits 15:0 of word 0 (RCV <= HIGH+6).
- R7: When a stop (cmd_i = 3) is accepted, sda_o goes to 0 and scl_o stays 0 for LOW+2 cycles. scl_o is then 1 for HIGH+7 cycles with sda_o still 0, after which sda_o rises.
- R8: After sda_o rises at the end of a stop, cmd_ready_o stays 0 for FREE cycles and then returns to 1. FREE is bits 31:16 of word 2 (FREE >= 1).
- R9: Commands are encoded as 0 = no-op, 1 = start, 2 = bit and 3 = stop. In idle, anything other than a start is ignored. While parked after a start, anything other than a bit or a stop is ignored. An ignored command changes no output.
- R10: The timing words are captured only when a start is accepted. Changing them during a transfer does not alter any phase of that transfer.
- R11: cmd_ready_o is 1 only in idle and while parked with SCL low. It is 0 while a start lead-in, a bit, a stop or the bus-free wait is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmg_high_rcv_i | input | 32 | Word 0: high count [31:16], receive sample offset [15:0] |
| tmg_low_xmit_i | input | 32 | Word 1: low count [31:16], drive offset [15:0] |
| tmg_free_lead_i | input | 32 | Word 2: bus-free count [31:16], lead-in count [15:0] |
| cmd_valid_i | input | 1 | Command present |
| cmd_i | input | 2 | Command code: 0 no-op, 1 start, 2 bit, 3 stop |
| bit_i | input | 1 | Data bit for a bit command |
| cmd_ready_o | output | 1 | Command can be accepted |
| scl_o | output | 1 | SCL level |
| sda_o | output | 1 | SDA level |
| drive_stb_o | output | 1 | One-cycle pulse in a low phase: SDA changes next cycle |
| sample_stb_o | output | 1 | One-cycle pulse in a high phase: SDA may be read |

## Verification
The bench predicts every SCL and SDA edge and every strobe to the exact cycle, and it checks them in order. It uses four timing sets:
- A mid-range set, where all counts differ, so that swapped fields show up as wrong offsets.
- A minimum set (counts 1 and offsets 0), where strobes land on phase boundaries.
- A set with both offsets at their upper limits, so that the drive change coincides with the SCL rise.
- A set with 1023-cycle phases, which catches truncated counters.

Bit values alternate and repeat, so an SDA update missing or placed a cycle off is visible. Illegal commands in idle and in the parked state, and timing words rewritten mid-transfer, must leave no trace on the pins.

// File: rtl/i2c_tmr_pkg.sv
package i2c_tmr_pkg;
  localparam int unsigned FW       = 16;
  localparam int unsigned WW       = 2 * FW;
  localparam int unsigned LOW_ADD  = 2;
  localparam int unsigned HIGH_ADD = 7;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_START = 2'd1,
    CMD_BIT   = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HOLD, ST_LOW, ST_HIGH, ST_PLOW, ST_PHIGH, ST_FREE
  } st_e;

  typedef struct packed {
    logic [FW-1:0] high;
    logic [FW-1:0] rcv;
    logic [FW-1:0] low;
    logic [FW-1:0] xmit;
    logic [FW-1:0] bfree;
    logic [FW-1:0] lead;
  } tmg_t;
endpackage

// File: rtl/i2c_tmr_cfg.sv
module i2c_tmr_cfg
  import i2c_tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] w0_i,
  input  logic [WW-1:0] w1_i,
  input  logic [WW-1:0] w2_i,
  output tmg_t          cfg_o
);
  tmg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (load_i) begin
      cfg_q.high  <= w0_i[WW-1:FW];
      cfg_q.rcv   <= w0_i[FW-1:0];
      cfg_q.low   <= w1_i[WW-1:FW];
      cfg_q.xmit  <= w1_i[FW-1:0];
      cfg_q.bfree <= w2_i[WW-1:FW];
      cfg_q.lead  <= w2_i[FW-1:0];
    end
  end

  assign cfg_o = cfg_q;

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));
endmodule

// File: rtl/i2c_tmr_seq.sv
module i2c_tmr_seq
  import i2c_tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_i,
  input  logic       bit_i,
  input  tmg_t       cfg_i,
  output logic       load_o,
  output logic       ready_o,
  output logic       scl_o,
  output logic       sda_o,
  output logic       drive_stb_o,
  output logic       sample_stb_o
);
  st_e           st_q, st_d;
  logic [FW-1:0] cnt_q;
  logic          sda_q, bit_q;
  logic          accept;
  cmd_e          cmd;
  logic [FW-1:0] low_end, high_end, lead_end, free_end;

  assign cmd      = cmd_e'(cmd_i);
  assign ready_o  = (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign accept   = cmd_valid_i && ready_o;
  assign low_end  = cfg_i.low  + FW'(LOW_ADD - 1);
  assign high_end = cfg_i.high + FW'(HIGH_ADD - 1);
  assign lead_end = cfg_i.lead - FW'(1);
  assign free_end = cfg_i.bfree - FW'(1);
  assign load_o   = accept && (st_q == ST_IDLE) && (cmd == CMD_START);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (load_o) st_d = ST_LEAD;
      ST_LEAD:  if (cnt_q == lead_end) st_d = ST_HOLD;
      ST_HOLD: begin
        if (accept && cmd == CMD_BIT)  st_d = ST_LOW;
        if (accept && cmd == CMD_STOP) st_d = ST_PLOW;
      end
      ST_LOW:   if (cnt_q == low_end)  st_d = ST_HIGH;
      ST_HIGH:  if (cnt_q == high_end) st_d = ST_HOLD;
      ST_PLOW:  if (cnt_q == low_end)  st_d = ST_PHIGH;
      ST_PHIGH: if (cnt_q == high_end) st_d = ST_FREE;
      ST_FREE:  if (cnt_q == free_end) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_d != st_q) ? '0 : cnt_q + FW'(1);
    end
  end

  assign drive_stb_o  = (st_q == ST_LOW)  && (cnt_q == cfg_i.xmit);
  assign sample_stb_o = (st_q == ST_HIGH) && (cnt_q == cfg_i.rcv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      bit_q <= 1'b1;
    end else begin
      if (load_o) sda_q <= 1'b0;
      if (st_q == ST_HOLD && accept && cmd == CMD_STOP) sda_q <= 1'b0;
      if (st_q == ST_HOLD && accept && cmd == CMD_BIT)  bit_q <= bit_i;
      if (drive_stb_o) sda_q <= bit_q;
      if (st_q == ST_PHIGH && cnt_q == high_end) sda_q <= 1'b1;
    end
  end

  assign scl_o = !((st_q == ST_HOLD) || (st_q == ST_LOW) || (st_q == ST_PLOW));
  assign sda_o = sda_q;

  // R6
  sample_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_stb_o |-> scl_o);
  // R5
  drive_in_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_stb_o |-> !scl_o);
  // R5
  drive_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_stb_o |=> (sda_o == $past(bit_q)));
  // R2
  start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o && cmd_i == 2'd1 && scl_o && sda_o) |=> (scl_o && !sda_o));
  // R8
  busfree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_o) && scl_o) |-> !ready_o);
  // R9
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && ready_o && cmd_i != 2'd1 && scl_o && sda_o) |=> (ready_o && scl_o && sda_o));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [WW-1:0] tmg_high_rcv_i,
  input  logic [WW-1:0] tmg_low_xmit_i,
  input  logic [WW-1:0] tmg_free_lead_i,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_i,
  input  logic          bit_i,
  output logic          cmd_ready_o,
  output logic          scl_o,
  output logic          sda_o,
  output logic          drive_stb_o,
  output logic          sample_stb_o
);
  tmg_t cfg;
  logic load;

  i2c_tmr_cfg i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .w0_i   (tmg_high_rcv_i),
    .w1_i   (tmg_low_xmit_i),
    .w2_i   (tmg_free_lead_i),
    .cfg_o  (cfg)
  );

  i2c_tmr_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (cmd_i),
    .bit_i        (bit_i),
    .cfg_i        (cfg),
    .load_o       (load),
    .ready_o      (cmd_ready_o),
    .scl_o        (scl_o),
    .sda_o        (sda_o),
    .drive_stb_o  (drive_stb_o),
    .sample_stb_o (sample_stb_o)
  );
endmodule

// File: tb/test_i2c_scl_timer.sv
module test_i2c_scl_timer;
  localparam int K_SDA_R = 0, K_SDA_F = 1, K_SCL_R = 2, K_SCL_F = 3, K_DRV = 4, K_SMP = 5;

  typedef struct {
    int    kind;
    int    at;
    string req;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] w0 = '0, w1 = '0, w2 = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd = 2'd0;
  logic        bit_in = 1'b0;
  logic        ready, scl, sda, drv, smp;

  int  cyc = 0;
  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  ev_t exp_q[$];
  int  w_hi, w_rc, w_lo, w_xm, w_bf, w_ld;
  int  m_hi, m_rc, m_lo, m_xm, m_bf, m_ld;
  logic sda_m = 1'b1;
  logic scl_p = 1'b1, sda_p = 1'b1;

  i2c_scl_timer i_i2c_scl_timer (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .tmg_high_rcv_i  (w0),
    .tmg_low_xmit_i  (w1),
    .tmg_free_lead_i (w2),
    .cmd_valid_i     (cmd_valid),
    .cmd_i           (cmd),
    .bit_i           (bit_in),
    .cmd_ready_o     (ready),
    .scl_o           (scl),
    .sda_o           (sda),
    .drive_stb_o     (drv),
    .sample_stb_o    (smp)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(input int k, input int at, input string req);
    ev_t e;
    e.kind = k; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(input int k);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R9 unexpected event: actual kind %0d at %0d expected none", k, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.at != cyc) begin
        n_fail++;
        $display("FAIL %s: actual kind %0d at %0d expected kind %0d at %0d",
                 e.req, k, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda !== sda_p) observe(sda ? K_SDA_R : K_SDA_F);
      if (scl !== scl_p) observe(scl ? K_SCL_R : K_SCL_F);
      if (drv) observe(K_DRV);
      if (smp) observe(K_SMP);
      sda_p = sda;
      scl_p = scl;
    end
  end

  task automatic set_words(input int hi, rc, lo, xm, bf, ld);
    w0 = {hi[15:0], rc[15:0]};
    w1 = {lo[15:0], xm[15:0]};
    w2 = {bf[15:0], ld[15:0]};
    w_hi = hi; w_rc = rc; w_lo = lo; w_xm = xm; w_bf = bf; w_ld = ld;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] c, input logic b, output int a);
    wait_ready();
    a = cyc + 1;
    cmd = c; bit_in = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 2'd0; bit_in = 1'b0;
  endtask

  task automatic do_start();
    int a;
    wait_ready();
    m_hi = w_hi; m_rc = w_rc; m_lo = w_lo; m_xm = w_xm; m_bf = w_bf; m_ld = w_ld;
    push(K_SDA_F, cyc + 1, "R2");
    push(K_SCL_F, cyc + 1 + m_ld, "R2");
    issue(2'd1, 1'b0, a);
    sda_m = 1'b0;
    check(ready == 1'b0, "R11", ready, 0);
  endtask

  task automatic do_bit(input logic b);
    int a;
    wait_ready();
    a = cyc + 1;
    push(K_DRV, a + m_xm, "R5");
    if (b != sda_m) push(b ? K_SDA_R : K_SDA_F, a + m_xm + 1, "R5");
    push(K_SCL_R, a + m_lo + 2, "R3");
    push(K_SMP, a + m_lo + 2 + m_rc, "R6");
    push(K_SCL_F, a + m_lo + 2 + m_hi + 7, "R4");
    issue(2'd2, b, a);
    sda_m = b;
    check(ready == 1'b0, "R11", ready, 0);
  endtask

  task automatic do_stop();
    int a, exp_rdy;
    wait_ready();
    a = cyc + 1;
    if (sda_m) push(K_SDA_F, a, "R7");
    push(K_SCL_R, a + m_lo + 2, "R7");
    push(K_SDA_R, a + m_lo + 2 + m_hi + 7, "R7");
    exp_rdy = a + m_lo + 2 + m_hi + 7 + m_bf;
    issue(2'd3, 1'b0, a);
    sda_m = 1'b1;
    wait_ready();
    check(cyc == exp_rdy, "R8", cyc, exp_rdy);
  endtask

  task automatic try_ignored(input logic [1:0] c, input logic exp_scl);
    int a;
    issue(c, 1'b1, a);
    repeat (2) @(negedge clk);
    check(ready == 1'b1 && scl == exp_scl && sda == sda_m, "R9",
          {ready, scl, sda}, {1'b1, exp_scl, sda_m});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    set_words(20, 7, 30, 11, 15, 9);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scl && sda && ready && !drv && !smp, "R1",
          {scl, sda, ready, drv, smp}, 5'b11100);

    // mid-range set
    do_start();
    do_bit(1'b1); do_bit(1'b0); do_bit(1'b1); do_bit(1'b1);
    do_stop();

    // R9: non-start commands in idle
    try_ignored(2'd2, 1'b1);
    try_ignored(2'd3, 1'b1);

    // minimum set, R10 rewrite mid-transfer
    set_words(1, 0, 1, 0, 1, 1);
    do_start();
    try_ignored(2'd1, 1'b0);
    try_ignored(2'd0, 1'b0);
    do_bit(1'b0); do_bit(1'b1);
    set_words(20, 7, 30, 11, 15, 9);
    do_bit(1'b0);
    do_stop();

    // offsets at upper limits
    set_words(5, 11, 3, 4, 3, 2);
    do_start();
    do_bit(1'b1); do_bit(1'b0); do_bit(1'b0);
    do_stop();

    // long phases
    set_words(1023, 1029, 1023, 1024, 40, 100);
    do_start();
    do_bit(1'b1);
    do_stop();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule